// File: doc/BRIEF.md
# Mutation-Only Evolutionary Search Engine

This block runs an evolutionary search over fixed-width binary chromosomes and uses mutation alone, with no recombination. After `start`, it fills a first population of N random chromosomes and has every one scored. The best scorer becomes the parent. Every later generation holds N+1 children, and each child is the parent with a few bits flipped. A 16-bit shift-register generator supplies both the random chromosomes and the flip positions. The fitness function sits outside the block. Each child goes out on a valid/ready stream, and the outside evaluator returns one score per child on a fitness-valid strobe.

The engine tracks the best chromosome seen so far. At the end of each generation it stops when the best score has reached the target, or when the configured number of mutation generations has run. It then raises `done` and holds `best_chrom` and `best_fit` steady until the next `start`.

Back-pressure rules for the candidate stream:
- While `cand_valid` is high and `cand_ready` is low, the candidate is held unchanged.
- A candidate is consumed on the first clock edge where both `cand_valid` and `cand_ready` are high.
- After that, no further candidate is offered until a `fit_valid` strobe has returned that child's score.

Top module: `mut_search_engine`

## Requirements
- R1: After reset, `cand_valid` and `done` are 0, and `best_chrom` and `best_fit` are 0.
- R2: The generator shifts left and feeds in s[15]^s[13]^s[12]^s[10] (maximal length, period 65535). `start` loads it from `seed`, and a seed of 0 is loaded as 1. A random chromosome is built from K=ceil(W/16) successive generator outputs. Each output is appended at the least significant end, so the earliest output ends up most significant, and the result keeps the low W bits.
- R3: The first generation is exactly N random chromosomes, offered and scored in order before any mutated child appears.
- R4: Each later generation has N+1 children, and each child starts as a copy of the parent. Child 0 flips one bit. Every other child flips F bits, where F is `flip_count` latched at `start`, and a value of 0 means 1. Each flip advances the generator once and toggles bit (new state mod W). A position hit twice is restored.
- R5: A score replaces the best when it is greater than or equal to the best score, so ties go to the newer child. The first child of a run is always taken. The parent of each generation is the best at the end of the previous generation.
- R6: While `cand_valid` is high and `cand_ready` is low, `cand_data` is stable. After a handshake, `cand_valid` is low until `fit_valid` has been taken.
- R7: A `fit_valid` strobe while no child is awaiting a score has no effect.
- R8: At each generation's end the engine stops if best ≥ `target_fit`, or if the number of completed mutation generations equals `max_gens` (0 stops after the first population). While stopped, `done` is 1, `cand_valid` is 0, and the best outputs are held.
- R9: `start` is ignored while a run is in progress. `start` after `done` begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (idle or done only) |
| seed | input | 16 | Generator seed, latched at start |
| flip_count | input | 2 | Bits flipped per child after child 0 (0 means 1) |
| target_fit | input | FW | Stop once best score reaches this |
| max_gens | input | GW | Mutation generation limit |
| cand_valid | output | 1 | Candidate chromosome offered |
| cand_ready | input | 1 | Evaluator accepts candidate |
| cand_data | output | W | Candidate chromosome |
| fit_valid | input | 1 | Score strobe for the outstanding child |
| fit_score | input | FW | Score value |
| done | output | 1 | Search finished |
| best_chrom | output | W | Best chromosome so far |
| best_fit | output | FW | Score of best chromosome |

## Verification
The hardest cases to reach from the ports are the selection corners. One is a run of equal scores, where the tie rule decides which child becomes the next parent. Another is the generation on which the stop condition triggers. A constant-score evaluator drives every tie through the newest-child path. A zero generation limit forces a stop straight after the random population. A popcount score with a reachable target lets the search stop on the target, in whatever generation that happens. A stray score strobe sent before start, and a start pulse sent mid-run, must both leave every candidate and the final best exactly as the bench's own model predicts.

// File: rtl/mse_pkg.sv
package mse_pkg;
  localparam int RW = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_BUILD, S_OFFER, S_SCORE, S_EVAL, S_DONE
  } phase_t;

  function automatic logic [RW-1:0] lfsr_adv(input logic [RW-1:0] s);
    return {s[RW-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/mse_lfsr.sv
module mse_lfsr
  import mse_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] seed,
  input  logic          step,
  output logic [RW-1:0] nxt
);
  logic [RW-1:0] state;

  assign nxt = lfsr_adv(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= RW'(1);
    else if (load)
      state <= (seed == '0) ? RW'(1) : seed;
    else if (step)
      state <= nxt;
  end
endmodule

// File: rtl/mse_builder.sv
module mse_builder
  import mse_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          shift_en,
  input  logic          flip_en,
  input  logic [RW-1:0] rnd,
  output logic [W-1:0]  chrom
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;

  logic [W+RW-1:0] shifted;
  logic [PW-1:0]   pos;
  logic [W-1:0]    mask;

  assign shifted = {chrom, rnd};
  assign pos     = PW'(rnd % RW'(W));
  assign mask    = W'(1) << pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chrom <= '0;
    else if (load)
      chrom <= load_val;
    else if (shift_en)
      chrom <= shifted[W-1:0];
    else if (flip_en)
      chrom <= chrom ^ mask;
  end
endmodule

// File: rtl/mse_best.sv
module mse_best #(
  parameter int W  = 32,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          offer,
  input  logic [W-1:0]  cand,
  input  logic [FW-1:0] score,
  output logic [W-1:0]  best_chrom,
  output logic [FW-1:0] best_fit
);
  logic have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have       <= 1'b0;
      best_chrom <= '0;
      best_fit   <= '0;
    end else if (clear) begin
      have       <= 1'b0;
      best_chrom <= '0;
      best_fit   <= '0;
    end else if (offer && (!have || score >= best_fit)) begin
      have       <= 1'b1;
      best_chrom <= cand;
      best_fit   <= score;
    end
  end
endmodule

// File: rtl/mut_search_engine.sv
module mut_search_engine
  import mse_pkg::*;
#(
  parameter int W  = 32,
  parameter int N  = 4,
  parameter int FW = 16,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   seed,
  input  logic [1:0]    flip_count,
  input  logic [FW-1:0] target_fit,
  input  logic [GW-1:0] max_gens,
  output logic          cand_valid,
  input  logic          cand_ready,
  output logic [W-1:0]  cand_data,
  input  logic          fit_valid,
  input  logic [FW-1:0] fit_score,
  output logic          done,
  output logic [W-1:0]  best_chrom,
  output logic [FW-1:0] best_fit
);
  localparam int K   = (W + RW - 1) / RW;
  localparam int CIW = $clog2(N + 2);
  localparam int SW  = $clog2(K + 4);

  phase_t         st;
  logic [CIW-1:0] child_idx;
  logic [SW-1:0]  step_cnt, step_need;
  logic [GW-1:0]  gen_cnt, gen_done, maxgen_q;
  logic           init_ph;
  logic [W-1:0]   parent, work, b_val;
  logic [1:0]     flips_q;
  logic [FW-1:0]  target_q;
  logic [RW-1:0]  rnd;
  logic           go, take_fit, last_child, finish;
  logic           lf_step, b_load, b_shift, b_flip;

  assign go         = start && (st == S_IDLE || st == S_DONE);
  assign take_fit   = (st == S_SCORE) && fit_valid;
  assign last_child = init_ph ? (child_idx == CIW'(N - 1)) : (child_idx == CIW'(N));
  assign gen_done   = gen_cnt + GW'(!init_ph);
  assign finish     = (best_fit >= target_q) || (gen_done == maxgen_q);
  assign lf_step    = (st == S_BUILD);
  assign b_shift    = lf_step && init_ph;
  assign b_flip     = lf_step && !init_ph;

  always_comb begin
    if (init_ph)             step_need = SW'(K);
    else if (child_idx == 0) step_need = SW'(1);
    else                     step_need = SW'(flips_q);
  end

  always_comb begin
    b_load = 1'b0;
    b_val  = parent;
    if (take_fit && !last_child && !init_ph) b_load = 1'b1;
    if (st == S_EVAL && !finish) begin
      b_load = 1'b1;
      b_val  = best_chrom;
    end
  end

  mse_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(go), .seed(seed),
    .step(lf_step), .nxt(rnd)
  );

  mse_builder #(.W(W)) u_build (
    .clk(clk), .rst_n(rst_n), .load(b_load), .load_val(b_val),
    .shift_en(b_shift), .flip_en(b_flip), .rnd(rnd), .chrom(work)
  );

  mse_best #(.W(W), .FW(FW)) u_best (
    .clk(clk), .rst_n(rst_n), .clear(go), .offer(take_fit),
    .cand(work), .score(fit_score),
    .best_chrom(best_chrom), .best_fit(best_fit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      child_idx <= '0;
      step_cnt  <= '0;
      gen_cnt   <= '0;
      init_ph   <= 1'b1;
      parent    <= '0;
      flips_q   <= 2'd1;
      target_q  <= '0;
      maxgen_q  <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (go) begin
          flips_q   <= (flip_count == 2'd0) ? 2'd1 : flip_count;
          target_q  <= target_fit;
          maxgen_q  <= max_gens;
          init_ph   <= 1'b1;
          child_idx <= '0;
          step_cnt  <= '0;
          gen_cnt   <= '0;
          st        <= S_BUILD;
        end
        S_BUILD: begin
          if (step_cnt == step_need - SW'(1)) begin
            step_cnt <= '0;
            st       <= S_OFFER;
          end else begin
            step_cnt <= step_cnt + SW'(1);
          end
        end
        S_OFFER: if (cand_ready) st <= S_SCORE;
        S_SCORE: if (fit_valid) begin
          if (last_child) begin
            st <= S_EVAL;
          end else begin
            child_idx <= child_idx + CIW'(1);
            st        <= S_BUILD;
          end
        end
        S_EVAL: begin
          gen_cnt <= gen_done;
          if (finish) begin
            st <= S_DONE;
          end else begin
            parent    <= best_chrom;
            init_ph   <= 1'b0;
            child_idx <= '0;
            st        <= S_BUILD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cand_valid = (st == S_OFFER);
  assign cand_data  = work;
  assign done       = (st == S_DONE);
endmodule

// File: rtl/mse_search_chk.sv
module mse_search_chk #(
  parameter int W  = 32,
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          cand_valid,
  input logic          cand_ready,
  input logic [W-1:0]  cand_data,
  input logic          done,
  input logic [W-1:0]  best_chrom,
  input logic [FW-1:0] best_fit
);
  a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_data));

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready |=> !cand_valid);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cand_valid);

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(best_chrom) && $stable(best_fit));

  a_r5_best_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> best_fit >= $past(best_fit));
endmodule

bind mut_search_engine mse_search_chk #(.W(W), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cand_valid(cand_valid),
  .cand_ready(cand_ready), .cand_data(cand_data), .done(done),
  .best_chrom(best_chrom), .best_fit(best_fit)
);

// File: tb/mut_search_engine_test.sv
module mut_search_engine_test;
  localparam int W = 32, N = 4, FW = 16, GW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] seed = '0;
  logic [1:0] flip_count = 2'd1;
  logic [FW-1:0] target_fit = '0, score_mon = '0, fit_score;
  logic [GW-1:0] max_gens = '0;
  logic cand_valid, cand_ready = 1'b0, fv_mon = 1'b0, fv_stray = 1'b0, fit_valid;
  logic [W-1:0] cand_data, best_chrom;
  logic [FW-1:0] best_fit;
  logic done;

  assign fit_valid = fv_mon | fv_stray;
  assign fit_score = fv_stray ? 16'hFFFF : score_mon;

  always #10 clk = ~clk;

  mut_search_engine #(.W(W), .N(N), .FW(FW), .GW(GW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .flip_count(flip_count), .target_fit(target_fit), .max_gens(max_gens),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_data(cand_data),
    .fit_valid(fit_valid), .fit_score(fit_score), .done(done),
    .best_chrom(best_chrom), .best_fit(best_fit)
  );

  int n_checks = 0, n_fail = 0;
  int mode = 0, bp = 0, cyc = 0, hs_cnt = 0, dly = 0;
  bit pend = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic [W-1:0] exp_best_c;
  logic [FW-1:0] exp_best_f;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] fitf(input logic [W-1:0] c, input int md);
    if (md == 0) return FW'($countones(c));
    if (md == 1) return FW'(9);
    return FW'($countones(~(c ^ 32'hA5A50F0F)));
  endfunction

  function automatic logic [15:0] nx(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Driver model: pushes every expected candidate and the final best.
  task automatic build_model(input logic [15:0] sd, input logic [1:0] fl,
                             input logic [FW-1:0] tgt, input logic [GW-1:0] mg,
                             input int md);
    logic [15:0] s;
    logic [W-1:0] c, par;
    logic [FW-1:0] f;
    bit have;
    int gen, nf, eff;
    s = (sd == 0) ? 16'd1 : sd;
    eff = (fl == 0) ? 1 : int'(fl);
    have = 0; exp_best_c = '0; exp_best_f = '0;
    for (int i = 0; i < N; i++) begin
      c = '0;
      for (int k = 0; k < (W + 15) / 16; k++) begin
        s = nx(s);
        c = W'({c, s});
      end
      exp_q.push_back(c); tag_q.push_back("R3");
      f = fitf(c, md);
      if (!have || f >= exp_best_f) begin exp_best_c = c; exp_best_f = f; have = 1; end
    end
    gen = 0;
    while (!(exp_best_f >= tgt || gen == int'(mg))) begin
      par = exp_best_c;
      for (int j = 0; j < N + 1; j++) begin
        c = par;
        nf = (j == 0) ? 1 : eff;
        for (int k = 0; k < nf; k++) begin
          s = nx(s);
          c = c ^ (W'(1) << (s % W));
        end
        exp_q.push_back(c); tag_q.push_back("R4");
        f = fitf(c, md);
        if (f >= exp_best_f) begin exp_best_c = c; exp_best_f = f; end
      end
      gen++;
    end
  endtask

  // Monitor and evaluator: pops and compares on each handshake.
  always @(negedge clk) begin
    logic r;
    logic [W-1:0] e;
    string t;
    cyc++;
    fv_mon = 1'b0;
    if (pend) begin
      if (dly == 0) begin fv_mon = 1'b1; pend = 0; end
      else dly--;
    end
    r = (bp != 0) ? ((cyc % 3) == 0) : 1'b1;
    if (rst_n && cand_valid && r) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected candidate", 64'(cand_data), 64'd0);
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(cand_data == e, t, "candidate", 64'(cand_data), 64'(e));
        score_mon = fitf(e, mode);
        pend = 1; dly = hs_cnt % 3; hs_cnt++;
      end
    end
    cand_ready = r;
  end

  task automatic pulse_start(input logic [15:0] sd);
    @(negedge clk); seed = sd; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_case(input logic [15:0] sd, input logic [1:0] fl,
                          input logic [FW-1:0] tgt, input logic [GW-1:0] mg,
                          input int md, input int bpm, input bit disturb);
    logic [W-1:0] hc;
    logic [FW-1:0] hf;
    int waited;
    mode = md; bp = bpm;
    build_model(sd, fl, tgt, mg, md);
    flip_count = fl; target_fit = tgt; max_gens = mg;
    pulse_start(sd);
    waited = 0;
    while (!done) begin
      @(negedge clk);
      waited++;
      if (disturb && waited == 20) begin
        start = 1'b1; seed = 16'h1234;
        @(negedge clk); start = 1'b0;
      end
    end
    chk(done == 1'b1, "R8", "done", 64'(done), 64'd1);
    chk(best_chrom == exp_best_c, "R5", "best_chrom", 64'(best_chrom), 64'(exp_best_c));
    chk(best_fit == exp_best_f, "R5", "best_fit", 64'(best_fit), 64'(exp_best_f));
    chk(exp_q.size() == 0, "R4", "candidates left", 64'(exp_q.size()), 64'd0);
    hc = best_chrom; hf = best_fit;
    repeat (5) @(negedge clk);
    chk(done && !cand_valid, "R8", "quiet while done", 64'({done, cand_valid}), 64'b10);
    chk(best_chrom == hc && best_fit == hf, "R8", "best held", 64'(best_chrom), 64'(hc));
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !cand_valid, "R1", "reset flags", 64'({done, cand_valid}), 64'd0);
    chk(best_chrom == 0 && best_fit == 0, "R1", "reset best", 64'(best_chrom), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: stray score strobe with no child outstanding
    fv_stray = 1'b1; @(negedge clk); fv_stray = 1'b0;
    @(negedge clk);
    chk(best_fit == 0, "R7", "stray score ignored", 64'(best_fit), 64'd0);
    // R2 R3 R4 R9: unreachable target, limited gens, start pulse mid-run
    run_case(16'hACE1, 2'd1, 16'd40, 16'd3, 0, 0, 1'b1);
    // R2: zero seed, two flips, reachable target, back-pressure
    run_case(16'h0000, 2'd2, 16'd20, 16'd60, 0, 1, 1'b0);
    // R5: constant score, ties go to newest child, three flips
    run_case(16'h5A5A, 2'd3, 16'd40, 16'd2, 1, 1, 1'b0);
    // R8: limit of zero stops after the first population
    run_case(16'hBEEF, 2'd2, 16'd40, 16'd0, 0, 0, 1'b0);
    // R4: flip count 0 behaves as 1, pattern score
    run_case(16'h0F0F, 2'd0, 16'd26, 16'd50, 2, 1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule